// File: doc/BRIEF.md
# Dual Timer/Counter

This block holds two independent 16-bit count channels, each stored as a high byte and a low byte. Each channel counts either machine-cycle enable pulses or falling edges on its own external count pin. An external gate pin can hold a channel's counting off while the pin is low. A channel wraps on overflow and raises a sticky flag. A CPU reaches all state through a small register bus: a write port and a combinational read port with separate addresses.

One shared 8-bit mode register selects each channel's source, its gating and its width mode. The width modes are 13-bit, 16-bit, 8-bit with reload from the high byte, and a fourth mode. In that fourth mode channel 1 stops. Channel 0 splits into two 8-bit counters, and its high half borrows channel 1's run bit and flag.

Top module: `dual_tmr_top`

## Requirements
- R1: After reset every register reads 0. The addresses are 0 mode, 1 control, 2 channel-0 low, 3 channel-0 high, 4 channel-1 low, 5 channel-1 high. Unused addresses read 0.
- R2: While a channel's run bit (control bit 0 for channel 0, bit 1 for channel 1) is 0, its count bytes do not change.
- R3: With its source bit at 0 a channel advances once per cycle in which `mc_en` is high. With its source bit at 1 it advances once per falling edge of its count pin. The pin is synchronized over two clocks and sampled only in `mc_en` cycles.
- R4: With its gate bit at 1 a channel advances only while its gate pin (synchronized) is high.
- R5: Mode 00 counts 13 bits: the low byte's bits 4:0 carry into the high byte. Low-byte bits 7:5 keep their value. An overflow from 0x1F/0xFF clears the counted bits and sets the flag.
- R6: Mode 01 counts all 16 bits. 0xFFFF wraps to 0x0000 and sets the channel's flag.
- R7: Mode 10 counts only the low byte. When it passes 0xFF it is loaded with the high byte, which is left unchanged, and the flag is set.
- R8: Channel 1 in mode 11 holds both of its bytes regardless of its run bit.
- R9: Channel 0 in mode 11 runs its low byte as an 8-bit counter under its own source, gate and run settings, and it sets flag 0. Its high byte counts `mc_en` pulses while run bit 1 is set, and it sets flag 1.
- R10: Control bits 4 and 5 are flags 0 and 1. A flag stays set until a control write with that bit at 0 clears it.
- R11: A CPU write to a count byte in the same cycle as an increment sets that byte to the written value.
- R12: The mode register reads back as written. Its fields are bit 7 gate1, bit 6 source1, bits 5:4 mode1, bit 3 gate0, bit 2 source0 and bits 1:0 mode0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_en | input | 1 | Machine-cycle enable pulse |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |

## Verification
All state is visible only through the read port. A wrong count or mode decode therefore shows as a wrong byte at the first read after the offending `mc_en` cycle. A wrongly set or lost flag shows in the next control read, and it stays visible because the flags hold. A bad edge-history bit in the count-pin detector shows as an extra or missing count. That error appears two clock cycles plus one machine cycle after the pin moves.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
    parameter int BYTE_W = 8;
    parameter int ADDR_W = 3;
    parameter int NCH    = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } cnt_t;

    localparam logic [1:0] MD_W13   = 2'd0;
    localparam logic [1:0] MD_W16   = 2'd1;
    localparam logic [1:0] MD_RLD   = 2'd2;
    localparam logic [1:0] MD_SPLIT = 2'd3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_C0LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_C0HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_C1LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_C1HI = 3'd5;

    localparam int RUN_LSB  = 0;
    localparam int FLAG_LSB = 4;
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mc_en,
    input  logic [N-1:0] cnt_pin,
    input  logic [N-1:0] gate_pin,
    output logic [N-1:0] fall,
    output logic [N-1:0] gate_s
);
    typedef struct packed {
        logic [N-1:0][STAGES-1:0] cs;
        logic [N-1:0][STAGES-1:0] gs;
        logic [N-1:0]             prev;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        for (int i = 0; i < N; i++) begin
            sy_d.cs[i] = {sy_q.cs[i][STAGES-2:0], cnt_pin[i]};
            sy_d.gs[i] = {sy_q.gs[i][STAGES-2:0], gate_pin[i]};
            if (mc_en) sy_d.prev[i] = sy_q.cs[i][STAGES-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign fall[g]   = mc_en && sy_q.prev[g] && !sy_q.cs[g][STAGES-1];
        assign gate_s[g] = sy_q.gs[g][STAGES-1];
    end
endmodule

// File: rtl/dtc_chan.sv
module dtc_chan
    import dtc_pkg::*;
#(
    parameter int PRE_W = 5
) (
    input  logic [1:0] mode,
    input  logic       tick,
    input  logic       tick_hi,
    input  cnt_t       cur,
    output cnt_t       nxt,
    output logic       wrap,
    output logic       wrap_hi
);
    logic [PRE_W-1:0] pre;
    assign pre = cur.lo[PRE_W-1:0];

    always_comb begin
        nxt     = cur;
        wrap    = 1'b0;
        wrap_hi = 1'b0;
        case (mode)
            MD_W13: if (tick) begin
                if (&pre) begin
                    nxt.lo[PRE_W-1:0] = '0;
                    nxt.hi            = cur.hi + 1'b1;
                    wrap              = &cur.hi;
                end else begin
                    nxt.lo[PRE_W-1:0] = pre + 1'b1;
                end
            end
            MD_W16: if (tick) begin
                nxt  = cur + 1'b1;
                wrap = &cur;
            end
            MD_RLD: if (tick) begin
                if (&cur.lo) begin
                    nxt.lo = cur.hi;
                    wrap   = 1'b1;
                end else begin
                    nxt.lo = cur.lo + 1'b1;
                end
            end
            default: begin
                if (tick) begin
                    nxt.lo = cur.lo + 1'b1;
                    wrap   = &cur.lo;
                end
                if (tick_hi) begin
                    nxt.hi  = cur.hi + 1'b1;
                    wrap_hi = &cur.hi;
                end
            end
        endcase
    end
endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
    import dtc_pkg::*;
#(
    parameter int PRE_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic [NCH-1:0]    cnt_pin,
    input  logic [NCH-1:0]    gate_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int FIELD_W = BYTE_W / NCH;

    typedef struct packed {
        byte_t          mode;
        logic [NCH-1:0] run;
        logic [NCH-1:0] flag;
        cnt_t           c1;
        cnt_t           c0;
    } st_t;

    st_t st_d, st_q;

    logic [NCH-1:0] fall, gate_s, tick, tick_hi, wrap, wrap_hi;
    logic [NCH-1:0] gate_b, src_b;
    logic [1:0]     md [NCH];
    cnt_t           cur [NCH];
    cnt_t           nxt [NCH];
    logic           split0;

    dtc_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_en   (mc_en),
        .cnt_pin (cnt_pin),
        .gate_pin(gate_pin),
        .fall    (fall),
        .gate_s  (gate_s)
    );

    assign cur[0] = st_q.c0;
    assign cur[1] = st_q.c1;
    assign split0 = (md[0] == MD_SPLIT);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign md[g]     = st_q.mode[g*FIELD_W +: 2];
        assign src_b[g]  = st_q.mode[g*FIELD_W + 2];
        assign gate_b[g] = st_q.mode[g*FIELD_W + 3];
        if (g == 0) begin : g_first
            assign tick[g]    = st_q.run[g] && (!gate_b[g] || gate_s[g])
                                && (src_b[g] ? fall[g] : mc_en);
            assign tick_hi[g] = mc_en && st_q.run[1];
        end else begin : g_other
            assign tick[g]    = st_q.run[g] && (!gate_b[g] || gate_s[g])
                                && (src_b[g] ? fall[g] : mc_en)
                                && (md[g] != MD_SPLIT);
            assign tick_hi[g] = 1'b0;
        end
        dtc_chan #(.PRE_W(PRE_W)) u_chan (
            .mode   (md[g]),
            .tick   (tick[g]),
            .tick_hi(tick_hi[g]),
            .cur    (cur[g]),
            .nxt    (nxt[g]),
            .wrap   (wrap[g]),
            .wrap_hi(wrap_hi[g])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.c0 = nxt[0];
        st_d.c1 = nxt[1];
        if (wr_en) begin
            case (wr_addr)
                A_MODE: st_d.mode = wr_data;
                A_CTRL: begin
                    st_d.run  = wr_data[RUN_LSB  +: NCH];
                    st_d.flag = wr_data[FLAG_LSB +: NCH];
                end
                A_C0LO: st_d.c0.lo = wr_data;
                A_C0HI: st_d.c0.hi = wr_data;
                A_C1LO: st_d.c1.lo = wr_data;
                A_C1HI: st_d.c1.hi = wr_data;
                default: ;
            endcase
        end
        st_d.flag[0] = st_d.flag[0] | wrap[0];
        st_d.flag[1] = st_d.flag[1] | (split0 ? wrap_hi[0] : (wrap[1] | wrap_hi[1]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_MODE: rd_data = st_q.mode;
            A_CTRL: begin
                rd_data[RUN_LSB  +: NCH] = st_q.run;
                rd_data[FLAG_LSB +: NCH] = st_q.flag;
            end
            A_C0LO: rd_data = st_q.c0.lo;
            A_C0HI: rd_data = st_q.c0.hi;
            A_C1LO: rd_data = st_q.c1.lo;
            A_C1HI: rd_data = st_q.c1.hi;
            default: ;
        endcase
    end
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk
    import dtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [1:0]        md0,
    input logic [1:0]        md1,
    input logic              run0,
    input logic              flag0,
    input logic [15:0]       c0,
    input logic [15:0]       c1,
    input logic              tick0
);
    logic wr_c0, wr_c1, wr_ctl;
    assign wr_c0  = wr_en && (wr_addr == A_C0LO || wr_addr == A_C0HI);
    assign wr_c1  = wr_en && (wr_addr == A_C1LO || wr_addr == A_C1HI);
    assign wr_ctl = wr_en && (wr_addr == A_CTRL);

    AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && md0 != MD_SPLIT && !wr_c0) |=> $stable(c0)); // R2

    AST_WRAP16: assert property (@(posedge clk) disable iff (!rst_n)
        (md0 == MD_W16 && tick0 && c0 == 16'hFFFF && !wr_c0) |=> (c0 == 16'h0000 && flag0)); // R6

    AST_RELOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (md0 == MD_RLD && !(wr_en && wr_addr == A_C0HI)) |=> $stable(c0[15:8])); // R7

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (md1 == MD_SPLIT && !wr_c1) |=> $stable(c1)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag0 && !wr_ctl) |=> flag0); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_C0LO) |=> (c0[7:0] == $past(wr_data))); // R11
endmodule

bind dual_tmr_top dtc_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .md0    (st_q.mode[1:0]),
    .md1    (st_q.mode[5:4]),
    .run0   (st_q.run[0]),
    .flag0  (st_q.flag[0]),
    .c0     (st_q.c0),
    .c1     (st_q.c1),
    .tick0  (tick[0])
);

// File: tb/tb_dual_tmr_top.sv
`timescale 1ns/1ps
module tb_dual_tmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_en = 1'b0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit busy = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    localparam logic [2:0] MODE = 3'd0, CTRL = 3'd1, C0LO = 3'd2, C0HI = 3'd3,
                           C1LO = 3'd4, C1HI = 3'd5;

    always #4 clk = ~clk;

    dual_tmr_top dut (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // monitor: pops expected items and compares against the read port
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                busy = 1;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                #1;
                n_chk++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h",
                             it.tag, it.addr, rd_data, it.exp);
                end
                busy = 0;
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        do @(posedge clk); while (sb_q.size() != 0 || busy);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); mc_en = 1;
            @(negedge clk); mc_en = 0;
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 7; a++) expect_rd(3'(a), 8'h00, "R1 reset");

        // R12 mode register, R2 run gating, R6 16-bit wrap
        wr(MODE, 8'h01);
        expect_rd(MODE, 8'h01, "R12 mode readback");
        wr(C0LO, 8'hFD); wr(C0HI, 8'hFF);
        pulse(2);
        expect_rd(C0LO, 8'hFD, "R2 run off");
        wr(CTRL, 8'h01);
        pulse(2);
        expect_rd(C0LO, 8'hFF, "R3 timer counts pulses");
        pulse(1);
        expect_rd(C0LO, 8'h00, "R6 wrap low");
        expect_rd(C0HI, 8'h00, "R6 wrap high");
        expect_rd(CTRL, 8'h11, "R6 flag set");

        // R10 sticky flag and clear
        pulse(3);
        expect_rd(CTRL, 8'h11, "R10 flag sticky");
        wr(CTRL, 8'h01);
        expect_rd(CTRL, 8'h01, "R10 flag cleared");

        // R5 13-bit mode
        wr(CTRL, 8'h00); wr(MODE, 8'h00);
        wr(C0LO, 8'hFE); wr(C0HI, 8'hFF);
        wr(CTRL, 8'h01);
        pulse(1);
        expect_rd(C0LO, 8'hFF, "R5 prescale step");
        pulse(1);
        expect_rd(C0LO, 8'hE0, "R5 upper low bits kept");
        expect_rd(C0HI, 8'h00, "R5 wrap high");
        expect_rd(CTRL, 8'h11, "R5 flag");

        // R7 reload mode
        wr(CTRL, 8'h00); wr(MODE, 8'h02);
        wr(C0HI, 8'h80); wr(C0LO, 8'hFE);
        wr(CTRL, 8'h01);
        pulse(2);
        expect_rd(C0LO, 8'h80, "R7 reload");
        expect_rd(C0HI, 8'h80, "R7 high unchanged");
        expect_rd(CTRL, 8'h11, "R7 flag");
        pulse(1);
        expect_rd(C0LO, 8'h81, "R7 after reload");

        // R3 counter source: falling edges only
        wr(CTRL, 8'h00); wr(MODE, 8'h05);
        wr(C0LO, 8'h00); wr(C0HI, 8'h00);
        wr(CTRL, 8'h01);
        pulse(3);
        expect_rd(C0LO, 8'h00, "R3 no edge no count");
        @(negedge clk); cnt_pin[0] = 0; settle();
        pulse(3);
        expect_rd(C0LO, 8'h01, "R3 one falling edge");
        @(negedge clk); cnt_pin[0] = 1; settle();
        pulse(1);
        @(negedge clk); cnt_pin[0] = 0; settle();
        pulse(1);
        expect_rd(C0LO, 8'h02, "R3 second falling edge");

        // R4 gate pin
        wr(CTRL, 8'h00); wr(MODE, 8'h09);
        wr(C0LO, 8'h00); wr(C0HI, 8'h00);
        wr(CTRL, 8'h01);
        pulse(3);
        expect_rd(C0LO, 8'h00, "R4 gate low blocks");
        @(negedge clk); gate_pin[0] = 1; settle();
        pulse(2);
        expect_rd(C0LO, 8'h02, "R4 gate high counts");

        // R8 channel 1 stop
        wr(CTRL, 8'h00); wr(MODE, 8'h31);
        wr(C1LO, 8'h12); wr(C1HI, 8'h34);
        wr(CTRL, 8'h03);
        pulse(3);
        expect_rd(C1LO, 8'h12, "R8 low held");
        expect_rd(C1HI, 8'h34, "R8 high held");
        expect_rd(C0LO, 8'h05, "R8 channel 0 still runs");

        // R9 split mode
        wr(CTRL, 8'h00); wr(MODE, 8'h03);
        wr(C0LO, 8'hFE); wr(C0HI, 8'hFE);
        wr(C1LO, 8'h00); wr(C1HI, 8'h00);
        wr(CTRL, 8'h01);
        pulse(1);
        expect_rd(C0HI, 8'hFE, "R9 high needs run1");
        pulse(1);
        expect_rd(C0LO, 8'h00, "R9 low wraps");
        expect_rd(CTRL, 8'h11, "R9 low sets flag0");
        wr(CTRL, 8'h02);
        pulse(2);
        expect_rd(C0HI, 8'h00, "R9 high wraps");
        expect_rd(C0LO, 8'h00, "R9 low idle without run0");
        expect_rd(CTRL, 8'h22, "R9 high sets flag1");

        // R11 write beats increment
        wr(CTRL, 8'h00); wr(MODE, 8'h01);
        wr(C0LO, 8'h10); wr(C0HI, 8'h00);
        wr(CTRL, 8'h01);
        @(negedge clk);
        mc_en = 1; wr_en = 1; wr_addr = C0LO; wr_data = 8'h55;
        @(negedge clk);
        mc_en = 0; wr_en = 0;
        expect_rd(C0LO, 8'h55, "R11 write wins");
        expect_rd(C0HI, 8'h00, "R11 high unchanged");
        pulse(1);
        expect_rd(C0LO, 8'h56, "R11 counting resumes");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule